// File: doc/BRIEF.md
# Address-Strobed Set/Clear Control Register

This block is a 16-bit control register whose bits change only when a bus write cycle falls inside a 32-byte address window. The window sits at the top of a 16-bit address space. Its base is a parameter that defaults to 16'hFFC0. Each register bit owns two neighbouring addresses. A write to the odd address of a pair drives that bit to 1, and a write to the even address drives it to 0. The data bus plays no part, so the block has no data input. The address and the write strobe are enough to change any bit.

The register value is split into named fields for the rest of the system:
- a display mode field,
- a display base offset, together with the byte address derived from it,
- a memory page select bit,
- a CPU rate field,
- a memory size field,
- a flag that selects RAM or ROM for the upper half of the map.

All outputs are taken combinationally from the register. A write cycle therefore shows its effect right after the clock edge that samples it.

Top module: `addr_strobe_ctl`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) clears all 16 register bits, so every field output reads 0 on the following cycle.
- R2: A clock edge with wr high and an odd address in 16'hFFC0..16'hFFDF sets register bit number addr[4:1] to 1.
- R3: A clock edge with wr high and an even address in 16'hFFC0..16'hFFDF clears register bit number addr[4:1] to 0.
- R4: An in-window write changes only the bit it selects. The other 15 bits keep their values.
- R5: The register does not change at an edge where wr is low, or where addr[15:5] differs from 11'h7FE (address below 16'hFFC0 or above 16'hFFDF).
- R6: disp_mode[2:0] equals register bits 2..0. These bits are set or cleared through addresses FFC0/1 (bit 0), FFC2/3 (bit 1) and FFC4/5 (bit 2).
- R7: disp_offset[6:0] equals register bits 9..3, least significant first. Its bit 0 is driven by pair FFC6/7 and its bit 6 by pair FFD2/3.
- R8: disp_base equals disp_offset times 512, which is disp_offset shifted left by 9 within 16 bits.
- R9: page_sel is bit 10 (FFD4/5). cpu_rate[1:0] is bits 12..11 (FFD6/7, FFD8/9). mem_size[1:0] is bits 14..13 (FFDA/B, FFDC/D). upper_ram is bit 15 (FFDE/F).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 16 | Bus address of the current cycle |
| bus_wr | input | 1 | Write strobe, sampled at the rising edge |
| ctl_word | output | 16 | Whole register value |
| disp_mode | output | 3 | Display mode field |
| disp_offset | output | 7 | Display base offset field |
| disp_base | output | 16 | Display base byte address (offset * 512) |
| page_sel | output | 1 | Memory page select |
| cpu_rate | output | 2 | CPU rate field |
| mem_size | output | 2 | Memory size field |
| upper_ram | output | 1 | Map type: 1 selects RAM for the upper half |

## Verification
Every result is due one cycle after its stimulus. The register takes the write at the rising edge where wr is sampled, and each field, including the derived base address, follows combinationally from the register. The bench drives the address and strobe on the falling edge and updates its behavioural model at the next rising edge. It then compares every output on the following falling edge, half a period after the update, so each comparison sees the state that edge produced. A reset is checked the same way: all fields are expected at zero on the first falling edge after the edge that sampled rst.

// File: rtl/asc_pkg.sv
package asc_pkg;

  // Default geometry of the control window
  localparam int unsigned ASC_ADDR_W   = 16;
  localparam int unsigned ASC_NUM_BITS = 16;
  localparam logic [ASC_ADDR_W-1:0] ASC_WIN_BASE = 16'hFFC0;

  // Field widths, in register bit order from bit 0 upward
  localparam int unsigned ASC_MODE_W  = 3;
  localparam int unsigned ASC_OFS_W   = 7;
  localparam int unsigned ASC_PAGE_W  = 1;
  localparam int unsigned ASC_RATE_W  = 2;
  localparam int unsigned ASC_SIZE_W  = 2;
  localparam int unsigned ASC_MAP_W   = 1;

  // Display base granularity: 512 bytes per offset step
  localparam int unsigned ASC_BASE_SHIFT = 9;

endpackage

// File: rtl/asc_window_decode.sv
module asc_window_decode #(
  parameter int unsigned ADDR_W   = asc_pkg::ASC_ADDR_W,
  parameter int unsigned NUM_BITS = asc_pkg::ASC_NUM_BITS,
  parameter logic [ADDR_W-1:0] WIN_BASE = asc_pkg::ASC_WIN_BASE
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ADDR_W-1:0]   addr,
  input  logic                wr,
  output logic                hit,
  output logic [NUM_BITS-1:0] sel,
  output logic                set_val
);

  localparam int unsigned IDX_W   = $clog2(NUM_BITS);
  localparam int unsigned TAG_LSB = IDX_W + 1;

  // The tag is the address part above the bit index and the parity bit
  function automatic logic in_window(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:TAG_LSB] == WIN_BASE[ADDR_W-1:TAG_LSB];
  endfunction

  // Bit index of a pair: the address with its parity bit dropped
  function automatic logic [IDX_W-1:0] pair_index(input logic [ADDR_W-1:0] a);
    return a[TAG_LSB-1:1];
  endfunction

  logic [IDX_W-1:0] idx;

  assign hit     = wr && in_window(addr);
  assign idx     = pair_index(addr);
  assign set_val = addr[0];

  always_comb begin
    sel = '0;
    if (hit) sel[idx] = 1'b1;
  end

  // At most one bit is addressed by any bus cycle
  assert_single_select_R4: assert property (@(posedge clk) disable iff (rst)
    $onehot0(sel));

endmodule

// File: rtl/asc_bit_bank.sv
module asc_bit_bank #(
  parameter int unsigned NUM_BITS = asc_pkg::ASC_NUM_BITS
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_BITS-1:0] sel,
  input  logic                set_val,
  output logic [NUM_BITS-1:0] q
);

  for (genvar i = 0; i < NUM_BITS; i++) begin : g_cell
    always_ff @(posedge clk) begin
      if (rst)         q[i] <= 1'b0;
      else if (sel[i]) q[i] <= set_val;
    end

    // An odd address drives the selected bit to 1
    assert_odd_sets_R2: assert property (@(posedge clk) disable iff (rst)
      (sel[i] && set_val) |=> q[i]);

    // An even address drives the selected bit to 0
    assert_even_clears_R3: assert property (@(posedge clk) disable iff (rst)
      (sel[i] && !set_val) |=> !q[i]);

    // A bit that is not addressed keeps its value
    assert_unselected_holds_R4: assert property (@(posedge clk) disable iff (rst)
      !sel[i] |=> $stable(q[i]));
  end

endmodule

// File: rtl/asc_field_map.sv
module asc_field_map #(
  parameter int unsigned ADDR_W     = asc_pkg::ASC_ADDR_W,
  parameter int unsigned NUM_BITS   = asc_pkg::ASC_NUM_BITS,
  parameter int unsigned MODE_W     = asc_pkg::ASC_MODE_W,
  parameter int unsigned OFS_W      = asc_pkg::ASC_OFS_W,
  parameter int unsigned RATE_W     = asc_pkg::ASC_RATE_W,
  parameter int unsigned SIZE_W     = asc_pkg::ASC_SIZE_W,
  parameter int unsigned BASE_SHIFT = asc_pkg::ASC_BASE_SHIFT
) (
  input  logic [NUM_BITS-1:0] word,
  output logic [MODE_W-1:0]   mode,
  output logic [OFS_W-1:0]    offset,
  output logic [ADDR_W-1:0]   base,
  output logic                page,
  output logic [RATE_W-1:0]   rate,
  output logic [SIZE_W-1:0]   size,
  output logic                upper_ram
);

  // Field positions, packed upward from bit 0
  localparam int unsigned MODE_LSB = 0;
  localparam int unsigned OFS_LSB  = MODE_LSB + MODE_W;
  localparam int unsigned PAGE_POS = OFS_LSB + OFS_W;
  localparam int unsigned RATE_LSB = PAGE_POS + 1;
  localparam int unsigned SIZE_LSB = RATE_LSB + RATE_W;
  localparam int unsigned MAP_POS  = SIZE_LSB + SIZE_W;

  // Byte address of the display base for a given offset
  function automatic logic [ADDR_W-1:0] offset_to_base(input logic [OFS_W-1:0] o);
    return ADDR_W'(o) << BASE_SHIFT;
  endfunction

  assign mode      = word[OFS_LSB-1:MODE_LSB];
  assign offset    = word[PAGE_POS-1:OFS_LSB];
  assign page      = word[PAGE_POS];
  assign rate      = word[SIZE_LSB-1:RATE_LSB];
  assign size      = word[MAP_POS-1:SIZE_LSB];
  assign upper_ram = word[MAP_POS];
  assign base      = offset_to_base(offset);

endmodule

// File: rtl/addr_strobe_ctl.sv
module addr_strobe_ctl #(
  parameter int unsigned ADDR_W   = asc_pkg::ASC_ADDR_W,
  parameter int unsigned NUM_BITS = asc_pkg::ASC_NUM_BITS,
  parameter logic [ADDR_W-1:0] WIN_BASE = asc_pkg::ASC_WIN_BASE,
  parameter int unsigned MODE_W   = asc_pkg::ASC_MODE_W,
  parameter int unsigned OFS_W    = asc_pkg::ASC_OFS_W,
  parameter int unsigned RATE_W   = asc_pkg::ASC_RATE_W,
  parameter int unsigned SIZE_W   = asc_pkg::ASC_SIZE_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_wr,
  output logic [NUM_BITS-1:0] ctl_word,
  output logic [MODE_W-1:0]   disp_mode,
  output logic [OFS_W-1:0]    disp_offset,
  output logic [ADDR_W-1:0]   disp_base,
  output logic                page_sel,
  output logic [RATE_W-1:0]   cpu_rate,
  output logic [SIZE_W-1:0]   mem_size,
  output logic                upper_ram
);

  // Internal events, named for the checks
  logic                win_hit;
  logic [NUM_BITS-1:0] bit_sel;
  logic                bit_val;

  asc_window_decode #(
    .ADDR_W  (ADDR_W),
    .NUM_BITS(NUM_BITS),
    .WIN_BASE(WIN_BASE)
  ) u_decode (
    .clk    (clk),
    .rst    (rst),
    .addr   (bus_addr),
    .wr     (bus_wr),
    .hit    (win_hit),
    .sel    (bit_sel),
    .set_val(bit_val)
  );

  asc_bit_bank #(
    .NUM_BITS(NUM_BITS)
  ) u_bank (
    .clk    (clk),
    .rst    (rst),
    .sel    (bit_sel),
    .set_val(bit_val),
    .q      (ctl_word)
  );

  asc_field_map #(
    .ADDR_W  (ADDR_W),
    .NUM_BITS(NUM_BITS),
    .MODE_W  (MODE_W),
    .OFS_W   (OFS_W),
    .RATE_W  (RATE_W),
    .SIZE_W  (SIZE_W)
  ) u_fields (
    .word     (ctl_word),
    .mode     (disp_mode),
    .offset   (disp_offset),
    .base     (disp_base),
    .page     (page_sel),
    .rate     (cpu_rate),
    .size     (mem_size),
    .upper_ram(upper_ram)
  );

  // Reset empties the whole register one edge later
  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (ctl_word == '0));

  // No accepted write means no change at all
  assert_idle_holds_R5: assert property (@(posedge clk) disable iff (rst)
    !win_hit |=> $stable(ctl_word));

  // The derived base address always has its low nine bits clear
  assert_base_aligned_R8: assert property (@(posedge clk) disable iff (rst)
    disp_base[8:0] == 9'd0);

endmodule

// File: tb/addr_strobe_ctl_test.sv
module addr_strobe_ctl_test;

  logic        clk = 1'b0;
  logic        rst;
  logic [15:0] bus_addr;
  logic        bus_wr;
  logic [15:0] ctl_word;
  logic [2:0]  disp_mode;
  logic [6:0]  disp_offset;
  logic [15:0] disp_base;
  logic        page_sel;
  logic [1:0]  cpu_rate;
  logic [1:0]  mem_size;
  logic        upper_ram;

  int checks   = 0;
  int failures = 0;
  bit done     = 0;

  // Reference model: one integer per register bit
  int model [16];

  always #10 clk = ~clk;   // 50 MHz

  addr_strobe_ctl uut (
    .clk        (clk),
    .rst        (rst),
    .bus_addr   (bus_addr),
    .bus_wr     (bus_wr),
    .ctl_word   (ctl_word),
    .disp_mode  (disp_mode),
    .disp_offset(disp_offset),
    .disp_base  (disp_base),
    .page_sel   (page_sel),
    .cpu_rate   (cpu_rate),
    .mem_size   (mem_size),
    .upper_ram  (upper_ram)
  );

  function automatic int model_field(input int lsb, input int width);
    int v = 0;
    for (int k = 0; k < width; k++) v += model[lsb + k] * (1 << k);
    return v;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic compare_all(input string word_tag);
    int ofs;
    ofs = model_field(3, 7);
    check(word_tag,          int'(ctl_word),    model_field(0, 16));
    check("R6 disp_mode",    int'(disp_mode),   model_field(0, 3));
    check("R7 disp_offset",  int'(disp_offset), ofs);
    check("R8 disp_base",    int'(disp_base),   (ofs * 512) % 65536);
    check("R9 page_sel",     int'(page_sel),    model[10]);
    check("R9 cpu_rate",     int'(cpu_rate),    model_field(11, 2));
    check("R9 mem_size",     int'(mem_size),    model_field(13, 2));
    check("R9 upper_ram",    int'(upper_ram),   model[15]);
  endtask

  // One bus cycle: drive on the falling edge, model at the rising edge,
  // compare on the next falling edge
  task automatic step(input bit r, input int a, input bit w, input string tag);
    @(negedge clk);
    rst      = r;
    bus_addr = 16'(a);
    bus_wr   = w;
    @(posedge clk);
    if (r) begin
      for (int k = 0; k < 16; k++) model[k] = 0;
    end else if (w && a >= 16'hFFC0 && a <= 16'hFFDF) begin
      model[(a - 16'hFFC0) / 2] = a % 2;
    end
    @(negedge clk);
    compare_all(tag);
  endtask

  initial begin
    rst = 1'b1; bus_addr = 16'h0000; bus_wr = 1'b0;
    for (int k = 0; k < 16; k++) model[k] = 0;
    step(1, 16'h0000, 0, "R1 reset");
    step(1, 16'hFFC1, 1, "R1 reset with write");

    // Set every bit through its odd address
    for (int k = 0; k < 16; k++) step(0, 16'hFFC1 + 2 * k, 1, "R2 set");
    // Clear even bits through even addresses
    for (int k = 0; k < 16; k += 2) step(0, 16'hFFC0 + 2 * k, 1, "R3 clear");
    // Repeated set and clear of one bit
    step(0, 16'hFFD5, 1, "R2 repeat set");
    step(0, 16'hFFD4, 1, "R3 clear page");
    step(0, 16'hFFD4, 1, "R3 repeat clear");

    // Strobe low with in-window addresses
    step(0, 16'hFFC3, 0, "R5 strobe low");
    step(0, 16'hFFC4, 0, "R5 strobe low");
    // Just outside the window, and high-bit mismatch
    step(0, 16'hFFBF, 1, "R5 below window");
    step(0, 16'hFFE0, 1, "R5 above window");
    step(0, 16'hFFE2, 1, "R5 above window");
    step(0, 16'h7FC1, 1, "R5 tag mismatch");
    step(0, 16'hBFC0, 1, "R5 tag mismatch");

    // Offset walk: full value, then each bit alone
    for (int k = 0; k < 7; k++) step(0, 16'hFFC7 + 2 * k, 1, "R7 offset set");
    for (int k = 0; k < 7; k++) begin
      for (int j = 0; j < 7; j++)
        step(0, 16'hFFC6 + 2 * j + ((j == k) ? 1 : 0), 1, "R8 offset walk");
    end

    // Mixed traffic, half in the window
    for (int n = 0; n < 3000; n++) begin
      int a;
      if ($urandom_range(0, 1) == 1) a = 16'hFFC0 + $urandom_range(0, 31);
      else                           a = $urandom_range(0, 65535);
      step(($urandom_range(0, 199) == 0), a, $urandom_range(0, 1) == 1, "R4 mixed");
    end

    // Reset after a populated state
    for (int k = 0; k < 16; k++) step(0, 16'hFFC1 + 2 * k, 1, "R2 fill");
    step(1, 16'h0000, 0, "R1 late reset");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule